// File: doc/BRIEF.md
# Single-Bus Register-Transfer Datapath

This block is the 32-bit datapath of a microcoded processor in which every transfer crosses one shared bus. Four units can place a value on the bus: the register RAM, the immediate generator, the ALU and a memory read-data port. Four latches can take a value from it: operand registers A and B, the memory address register (MA) and the instruction register (IR). An external sequencer supplies a flat set of control signals every cycle. In return it receives the IR opcode, an ALU condition flag and the memory busy flag, which it uses for dispatch, branch decisions and wait loops.

The program counter is one slot of the register RAM, so fetch steps such as "MA,A := PC" and "PC := A+4" are plain bus transfers. The memory is a small synchronous model. After reset it holds a computed pattern, and every access makes it busy for a configurable number of cycles.

Top module: `sbd_datapath`

## Requirements
- R1: `bus_o` equals the value of the single enabled source: the register RAM (`reg_en`), the immediate unit (`imm_en`), the ALU result (`alu_en`) or the memory read-data register (`mem_en`).
- R2: At most one bus enable is active in a cycle. When none is active, `bus_o` reads as zero.
- R3: On a clock edge, A, B, MA and IR each take the bus value when their own load input (`a_ld`, `b_ld`, `ma_ld`, `ir_ld`) is high. Otherwise they hold their value.
- R4: `reg_sel` picks the register RAM entry: 0 = PC slot, 1 = rs1 (IR[19:15]), 2 = rs2 (IR[24:20]), 3 = rd (IR[11:7]). When `reg_wr` is high, the selected entry takes the bus value at the clock edge.
- R5: General register 0 always reads zero and ignores writes. The PC slot is separate from the 32 general entries. All entries reset to zero.
- R6: `imm_sel` 0 gives the I immediate (IR[31:20] sign-extended). 1 gives the branch immediate {IR[31], IR[7], IR[30:25], IR[11:8], 0}, sign-extended. 2 gives the jump immediate {IR[31], IR[19:12], IR[20], IR[30:21], 0}, sign-extended. 3 gives zero.
- R7: `alu_op` works on A and B only: 0 add, 1 subtract (A-B), 2 and, 3 or, 4 xor, 5 signed less-than (result 1/0), 6 unsigned less-than, 7 A+4.
- R8: `cond_o` is high exactly when the current ALU result is zero.
- R9: `opcode_o` is IR[6:0]. IR resets to zero.
- R10: An accepted `mem_req` (busy low) raises `busy_o` for `MEM_LAT` cycles. A write stores the bus value at the request edge. A read places the addressed word into the read-data register on the edge where busy drops. The word address is MA/4. Addresses at or beyond `4*MEM_DEPTH` read zero and drop writes.
- R11: A `mem_req` that arrives while `busy_o` is high is ignored. It does not extend busy and does not change the address in flight.
- R12: After reset, memory word i holds `i*32'h9E3779B1 ^ 32'h00518A13` (32-bit wrap-around).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imm_en | input | 1 | Immediate unit drives the bus |
| reg_en | input | 1 | Register RAM drives the bus |
| alu_en | input | 1 | ALU drives the bus |
| mem_en | input | 1 | Memory read-data register drives the bus |
| a_ld | input | 1 | Load A from the bus |
| b_ld | input | 1 | Load B from the bus |
| ma_ld | input | 1 | Load MA from the bus |
| ir_ld | input | 1 | Load IR from the bus |
| reg_sel | input | 2 | Register RAM entry select |
| reg_wr | input | 1 | Write the selected register from the bus |
| imm_sel | input | 2 | Immediate format select |
| alu_op | input | 3 | ALU operation |
| mem_req | input | 1 | Start a memory access at MA |
| mem_wr | input | 1 | The access is a write |
| bus_o | output | 32 | Shared bus value |
| opcode_o | output | 7 | IR opcode field |
| cond_o | output | 1 | ALU result is zero |
| busy_o | output | 1 | Memory access in progress |

## Verification
The bench runs a complete microcoded fetch–execute loop twice over every memory word. Each step is checked against a shadow model of the registers and memory. Register-0 writes are a key target: a design that honoured them would corrupt later rs1/rs2 reads. The three immediate layouts are checked on seeded instruction words with both sign polarities; a swapped bit group shows up directly on the bus. An out-of-range fetch at address 64 must return zero rather than alias word 0. A second request issued during a busy window must neither restart the countdown nor redirect the read; a design that accepted it would return the wrong word or hold busy too long.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  localparam int unsigned XLEN = 32;
  typedef logic [XLEN-1:0] word_t;

  typedef enum logic [1:0] {SEL_PC = 2'd0, SEL_RS1 = 2'd1, SEL_RS2 = 2'd2, SEL_RD = 2'd3} rsel_e;
  typedef enum logic [1:0] {IMM_I = 2'd0, IMM_B = 2'd1, IMM_J = 2'd2, IMM_ZERO = 2'd3} isel_e;
  typedef enum logic [2:0] {
    ALU_ADD = 3'd0, ALU_SUB = 3'd1, ALU_AND = 3'd2, ALU_OR = 3'd3,
    ALU_XOR = 3'd4, ALU_SLT = 3'd5, ALU_SLTU = 3'd6, ALU_INC4 = 3'd7
  } aluop_e;

  function automatic word_t mem_seed(int unsigned idx);
    return word_t'(idx) * 32'h9E37_79B1 ^ 32'h0051_8A13;
  endfunction

  function automatic word_t alu_eval(aluop_e op, word_t a, word_t b);
    word_t r;
    case (op)
      ALU_ADD:  r = a + b;
      ALU_SUB:  r = a - b;
      ALU_AND:  r = a & b;
      ALU_OR:   r = a | b;
      ALU_XOR:  r = a ^ b;
      ALU_SLT:  r = word_t'($signed(a) < $signed(b));
      ALU_SLTU: r = word_t'(a < b);
      default:  r = a + word_t'(4);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sbd_regfile.sv
module sbd_regfile
  import sbd_pkg::*;
#(
  parameter int unsigned NREG = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  rsel_e                   sel,
  input  logic [$clog2(NREG)-1:0] rs1,
  input  logic [$clog2(NREG)-1:0] rs2,
  input  logic [$clog2(NREG)-1:0] rd,
  input  logic                    wr,
  input  word_t                   wdata,
  output word_t                   rdata
);
  localparam int unsigned IW = $clog2(NREG);

  word_t          gpr [NREG];
  word_t          pc_q;
  logic [IW-1:0]  idx;
  logic           pick_pc;

  always_comb begin
    pick_pc = (sel == SEL_PC);
    case (sel)
      SEL_RS1: idx = rs1;
      SEL_RS2: idx = rs2;
      SEL_RD:  idx = rd;
      default: idx = '0;
    endcase
  end

  assign rdata = pick_pc ? pc_q : ((idx == '0) ? '0 : gpr[idx]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
      for (int i = 0; i < int'(NREG); i++) gpr[i] <= '0;
    end else if (wr) begin
      if (pick_pc) pc_q <= wdata;
      else if (idx != '0) gpr[idx] <= wdata;
    end
  end
endmodule

// File: rtl/sbd_immgen.sv
module sbd_immgen
  import sbd_pkg::*;
(
  input  word_t ir,
  input  isel_e sel,
  output word_t imm
);
  always_comb begin
    case (sel)
      IMM_I:   imm = {{20{ir[31]}}, ir[31:20]};
      IMM_B:   imm = {{19{ir[31]}}, ir[31], ir[7], ir[30:25], ir[11:8], 1'b0};
      IMM_J:   imm = {{11{ir[31]}}, ir[31], ir[19:12], ir[20], ir[30:21], 1'b0};
      default: imm = '0;
    endcase
  end
endmodule

// File: rtl/sbd_mem.sv
module sbd_mem
  import sbd_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned LAT   = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req,
  input  logic  wr,
  input  word_t addr,
  input  word_t wdata,
  output logic  busy,
  output logic  accept,
  output word_t rdata
);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(LAT + 1);

  word_t         words [DEPTH];
  logic [CW-1:0] cnt_q;
  word_t         pend_q;

  function automatic word_t word_no(word_t a);
    return a / word_t'(4);
  endfunction

  function automatic logic in_range(word_t a);
    return word_no(a) < word_t'(DEPTH);
  endfunction

  word_t new_wn, pend_wn;
  assign new_wn  = word_no(addr);
  assign pend_wn = word_no(pend_q);
  assign busy    = (cnt_q != '0);
  assign accept  = req && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= '0;
      rdata  <= '0;
      for (int i = 0; i < int'(DEPTH); i++) words[i] <= mem_seed(i);
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CW'(1))
        rdata <= in_range(pend_q) ? words[pend_wn[IW-1:0]] : '0;
    end else if (accept) begin
      cnt_q  <= CW'(LAT);
      pend_q <= addr;
      if (wr && in_range(addr)) words[new_wn[IW-1:0]] <= wdata;
    end
  end
endmodule

// File: rtl/sbd_datapath.sv
module sbd_datapath
  import sbd_pkg::*;
#(
  parameter int unsigned MEM_DEPTH = 16,
  parameter int unsigned MEM_LAT   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        imm_en,
  input  logic        reg_en,
  input  logic        alu_en,
  input  logic        mem_en,
  input  logic        a_ld,
  input  logic        b_ld,
  input  logic        ma_ld,
  input  logic        ir_ld,
  input  logic [1:0]  reg_sel,
  input  logic        reg_wr,
  input  logic [1:0]  imm_sel,
  input  logic [2:0]  alu_op,
  input  logic        mem_req,
  input  logic        mem_wr,
  output logic [31:0] bus_o,
  output logic [6:0]  opcode_o,
  output logic        cond_o,
  output logic        busy_o
);
  localparam int unsigned NSRC = 4;

  word_t a_q, b_q, ma_q, ir_q;
  word_t reg_rd, imm_val, alu_res, mem_rd;
  logic  mem_accept;
  logic [NSRC-1:0] drv_en;
  word_t           drv_val [NSRC];
  word_t           bus_w;

  // named source enables, one bit per bus driver
  assign drv_en     = {mem_en, alu_en, reg_en, imm_en};
  assign drv_val[0] = imm_val;
  assign drv_val[1] = reg_rd;
  assign drv_val[2] = alu_res;
  assign drv_val[3] = mem_rd;

  // AND-OR one-hot bus: reads zero with no driver
  always_comb begin
    bus_w = '0;
    for (int s = 0; s < int'(NSRC); s++)
      bus_w = bus_w | ({XLEN{drv_en[s]}} & drv_val[s]);
  end
  assign bus_o = bus_w;

  sbd_regfile #(.NREG(32)) u_rf (
    .clk(clk), .rst_n(rst_n), .sel(rsel_e'(reg_sel)),
    .rs1(ir_q[19:15]), .rs2(ir_q[24:20]), .rd(ir_q[11:7]),
    .wr(reg_wr), .wdata(bus_w), .rdata(reg_rd)
  );

  sbd_immgen u_imm (.ir(ir_q), .sel(isel_e'(imm_sel)), .imm(imm_val));

  assign alu_res = alu_eval(aluop_e'(alu_op), a_q, b_q);
  assign cond_o  = (alu_res == '0);

  sbd_mem #(.DEPTH(MEM_DEPTH), .LAT(MEM_LAT)) u_mem (
    .clk(clk), .rst_n(rst_n), .req(mem_req), .wr(mem_wr),
    .addr(ma_q), .wdata(bus_w), .busy(busy_o), .accept(mem_accept), .rdata(mem_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; ma_q <= '0; ir_q <= '0;
    end else begin
      if (a_ld)  a_q  <= bus_w;
      if (b_ld)  b_q  <= bus_w;
      if (ma_ld) ma_q <= bus_w;
      if (ir_ld) ir_q <= bus_w;
    end
  end

  assign opcode_o = ir_q[6:0];
endmodule

module sbd_datapath_chk #(
  parameter int unsigned MEM_LAT = 3
) (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  drv_en,
  input logic        ir_ld,
  input logic        mem_accept,
  input logic [31:0] bus_o,
  input logic [6:0]  opcode_o,
  input logic        busy_o
);
  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_run <= 0;
    else        busy_run <= busy_o ? busy_run + 1 : 0;
  end

  // R2
  bus_one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(drv_en) <= 1);
  // R2
  bus_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en == 4'b0) |-> (bus_o == 32'b0));
  // R9
  ir_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ir_ld |=> (opcode_o == $past(bus_o[6:0])));
  // R9
  opcode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_ld |=> $stable(opcode_o));
  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_accept |=> busy_o);
  // R11
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (busy_run < MEM_LAT));
endmodule

bind sbd_datapath sbd_datapath_chk #(.MEM_LAT(MEM_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .ir_ld(ir_ld),
  .mem_accept(mem_accept), .bus_o(bus_o), .opcode_o(opcode_o), .busy_o(busy_o)
);

// File: tb/sbd_datapath_tb_top.sv
module sbd_datapath_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int LAT   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic imm_en = 0, reg_en = 0, alu_en = 0, mem_en = 0;
  logic a_ld = 0, b_ld = 0, ma_ld = 0, ir_ld = 0;
  logic [1:0] reg_sel = 0, imm_sel = 0;
  logic reg_wr = 0, mem_req = 0, mem_wr = 0;
  logic [2:0] alu_op = 0;
  logic [31:0] bus_o;
  logic [6:0]  opcode_o;
  logic cond_o, busy_o;

  sbd_datapath #(.MEM_DEPTH(DEPTH), .MEM_LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .imm_en(imm_en), .reg_en(reg_en), .alu_en(alu_en),
    .mem_en(mem_en), .a_ld(a_ld), .b_ld(b_ld), .ma_ld(ma_ld), .ir_ld(ir_ld),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .imm_sel(imm_sel), .alu_op(alu_op),
    .mem_req(mem_req), .mem_wr(mem_wr), .bus_o(bus_o), .opcode_o(opcode_o),
    .cond_o(cond_o), .busy_o(busy_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // shadow model
  logic [31:0] m_rf [32];
  logic [31:0] m_pc, m_a, m_b, m_ma, m_ir, m_rdata, m_pend;
  logic [31:0] m_mem [DEPTH];
  int m_cnt;

  function automatic logic [31:0] seed_of(int i);
    logic [31:0] acc = 32'h0;
    for (int k = 0; k < i; k++) acc = acc + 32'h9E37_79B1;
    return acc ^ 32'h0051_8A13;
  endfunction

  function automatic logic [31:0] imm_of(logic [1:0] s, logic [31:0] ir);
    logic [31:0] v;
    case (s)
      2'd0: v = 32'($signed(ir) >>> 20);
      2'd1: v = (32'(ir[11:8]) << 1) | (32'(ir[30:25]) << 5) | (32'(ir[7]) << 11)
               | (ir[31] ? 32'hFFFF_F000 : 32'h0);
      2'd2: v = (32'(ir[30:21]) << 1) | (32'(ir[20]) << 11) | (32'(ir[19:12]) << 12)
               | (ir[31] ? 32'hFFF0_0000 : 32'h0);
      default: v = 32'h0;
    endcase
    return v;
  endfunction

  function automatic logic [31:0] alu_of(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    logic [31:0] v;
    case (op)
      3'd0: v = a + b;
      3'd1: v = a + ~b + 32'd1;
      3'd2: v = ~(~a | ~b);
      3'd3: v = ~(~a & ~b);
      3'd4: v = (a | b) & ~(a & b);
      3'd5: v = ((a[31] != b[31]) ? a[31] : (a < b)) ? 32'd1 : 32'd0;
      3'd6: v = (a < b) ? 32'd1 : 32'd0;
      default: v = a + 32'd4;
    endcase
    return v;
  endfunction

  function automatic int idx_of(logic [1:0] s);
    case (s)
      2'd1: return int'(m_ir[19:15]);
      2'd2: return int'(m_ir[24:20]);
      2'd3: return int'(m_ir[11:7]);
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] reg_of(logic [1:0] s);
    int i = idx_of(s);
    if (i < 0) return m_pc;
    if (i == 0) return 32'h0;
    return m_rf[i];
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // en: {mem,alu,reg,imm}; ld: {ir,ma,b,a}
  task automatic cyc(input logic [3:0] en, input logic [3:0] ld, input logic [1:0] sel,
                     input logic wr, input logic [1:0] isel, input logic [2:0] op,
                     input logic req, input logic mwr, input string tag);
    logic [31:0] eb, ea;
    string t;
    int widx;
    {mem_en, alu_en, reg_en, imm_en} = en;
    {ir_ld, ma_ld, b_ld, a_ld} = ld;
    reg_sel = sel; reg_wr = wr; imm_sel = isel; alu_op = op;
    mem_req = req; mem_wr = mwr;
    @(negedge clk);
    ea = alu_of(op, m_a, m_b);
    eb = en[0] ? imm_of(isel, m_ir) : en[1] ? reg_of(sel) :
         en[2] ? ea : en[3] ? m_rdata : 32'h0;
    if (tag != "") t = tag;
    else if (en[0]) t = "R6 immediate";
    else if (en[1]) t = (idx_of(sel) <= 0) ? "R5 pc/x0 read" : "R4 register read";
    else if (en[2]) t = "R7 R3 alu";
    else if (en[3]) t = "R10 mem data";
    else t = "R2 idle bus";
    chk({"R1 ", t}, bus_o, eb);
    chk("R8 cond", {31'b0, cond_o}, {31'b0, ea == 32'h0});
    chk("R9 opcode", {25'b0, opcode_o}, {25'b0, m_ir[6:0]});
    chk("R10 busy", {31'b0, busy_o}, {31'b0, m_cnt != 0});
    @(posedge clk);
    if (ld[0]) m_a = eb;
    if (ld[1]) m_b = eb;
    if (wr) begin
      widx = idx_of(sel);
      if (widx < 0) m_pc = eb;
      else if (widx > 0) m_rf[widx] = eb;
    end
    if (m_cnt != 0) begin
      if (m_cnt == 1) m_rdata = (m_pend / 4 < DEPTH) ? m_mem[m_pend / 4] : 32'h0;
      m_cnt--;
    end else if (req) begin
      m_cnt = LAT;
      m_pend = m_ma;
      if (mwr && (m_ma / 4 < DEPTH)) m_mem[m_ma / 4] = eb;
    end
    if (ld[2]) m_ma = eb;
    if (ld[3]) m_ir = eb;
    #1;
  endtask

  task automatic idle(input logic req, input logic mwr, input string tag);
    cyc(4'b0, 4'b0, 2'd0, 1'b0, 2'd0, 3'd0, req, mwr, tag);
  endtask

  task automatic spin();
    while (m_cnt != 0) idle(1'b0, 1'b0, "");
  endtask

  task automatic fetch(input string tag);
    cyc(4'b0010, 4'b0101, 2'd0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, "");   // MA,A := PC
    cyc(4'b0100, 4'b0000, 2'd0, 1'b1, 2'd0, 3'd7, 1'b1, 1'b0, "");   // PC := A+4, read
    spin();
    cyc(4'b1000, 4'b1000, 2'd0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, tag);  // IR := Mem
  endtask

  task automatic exec(input int k);
    cyc(4'b0010, 4'b0001, 2'd1, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, "");
    cyc(4'b0010, 4'b0010, 2'd2, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, "");
    cyc(4'b0100, 4'b0000, 2'd3, 1'b1, 2'd0, 3'(k % 8), 1'b0, 1'b0, "");
    cyc(4'b0001, 4'b0010, 2'd0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, "");
    cyc(4'b0100, 4'b0000, 2'd3, 1'b1, 2'd0, 3'd0, 1'b0, 1'b0, "");
    cyc(4'b0001, 4'b0000, 2'd0, 1'b0, 2'd1, 3'd0, 1'b0, 1'b0, "");
    cyc(4'b0001, 4'b0000, 2'd0, 1'b0, 2'd2, 3'd0, 1'b0, 1'b0, "");
    cyc(4'b0010, 4'b0001, 2'd3, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, "");
    cyc(4'b0100, 4'b0000, 2'd0, 1'b0, 2'd0, 3'd1, 1'b0, 1'b0, "");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) m_rf[i] = 32'h0;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = seed_of(i);
    m_pc = 0; m_a = 0; m_b = 0; m_ma = 0; m_ir = 0; m_rdata = 0; m_pend = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R2 reset bus", bus_o, 32'h0);
    chk("R9 reset opcode", {25'b0, opcode_o}, 32'h0);
    chk("R10 reset busy", {31'b0, busy_o}, 32'h0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    for (int p = 0; p < 2; p++) begin
      for (int w = 0; w < DEPTH; w++) begin
        fetch(p == 0 ? "R12 seed fetch" : "");
        exec(w + 3 * p);
      end
      fetch("R10 out-of-range read");
      cyc(4'b0001, 4'b0000, 2'd0, 1'b1, 2'd3, 3'd0, 1'b0, 1'b0, "R6 zero imm");  // PC := 0
    end

    // write then read back at address 8; a second request in flight is ignored
    cyc(4'b0001, 4'b0001, 2'd0, 1'b0, 2'd3, 3'd0, 1'b0, 1'b0, "");
    cyc(4'b0100, 4'b0001, 2'd0, 1'b0, 2'd0, 3'd7, 1'b0, 1'b0, "");
    cyc(4'b0100, 4'b0100, 2'd0, 1'b0, 2'd0, 3'd7, 1'b0, 1'b0, "");
    cyc(4'b0010, 4'b0000, 2'd3, 1'b0, 2'd0, 3'd0, 1'b1, 1'b1, "R10 write data");
    spin();
    idle(1'b1, 1'b0, "R10 read request");
    cyc(4'b0001, 4'b0100, 2'd0, 1'b0, 2'd3, 3'd0, 1'b1, 1'b0, "R11 req while busy");
    idle(1'b1, 1'b1, "R11 write while busy");
    spin();
    cyc(4'b1000, 4'b0001, 2'd0, 1'b0, 2'd0, 3'd0, 1'b0, 1'b0, "R11 readback");
    chk("R11 idle after window", {31'b0, busy_o}, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule